// File: doc/BRIEF.md
# DDS serial register file decoder

This block is the receive side of a three-wire serial control link for a direct digital synthesis core. A host shifts 16-bit frames in on a serial clock while holding an active-low frame sync. The decoder brings the three serial lines into the system clock domain and assembles each complete frame. It then updates one of five registers: a 14-bit control word, two 28-bit frequency tuning words and two 12-bit phase offsets.

The two top bits of a frame name its destination. Frequency words are wider than one frame, so the control word sets how a frequency frame is applied. In paired mode, two frames to the same frequency register make one atomic update. In split mode, each frame overwrites one chosen half. The register contents and the decoded control flags go straight to the waveform core.

Top module: `dds_regfile`

## Requirements
- R1: Frame bits [15:14] pick the destination: 00 loads bits [13:0] into the control word, 01 targets frequency word 0, 10 targets frequency word 1, 11 targets a phase word.
- R2: In a phase frame, bit 13 picks phase word 0 (clear) or 1 (set) and bits [11:0] become its value. A phase frame leaves the control word and both frequency words unchanged.
- R3: With control bit 13 set (paired mode), the first frequency frame is held as bits [13:0] and changes no output. The next frame to the same frequency register supplies bits [27:14], and the 28-bit word is updated in one step.
- R4: In paired mode, a held low half is discarded when the next frame goes to any other destination. A frame to the other frequency register becomes the new held low half.
- R5: With control bit 13 clear (split mode), a frequency frame overwrites bits [27:14] when control bit 12 is set and bits [13:0] when it is clear. The other half keeps its value.
- R6: Control flags come from fixed control bits: 11 frequency select, 10 phase select, 9 pin/software select, 8 core reset, 7 clock disable, 6 converter power-down, 5 sign output enable, 4 sign source, 3 divide-by-two, 1 triangle mode.
- R7: A frame ends early if sync goes high before 16 bits have arrived. Such a frame is discarded and changes no register. The next full frame is decoded normally.
- R8: After reset, every register and flag reads zero and split mode writes the low half.
- R9: Bits are taken MSB first, on falling edges of the serial clock while sync is low. The clock idles high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, idles high |
| sdata_i | input | 1 | Serial data, MSB first |
| sync_n_i | input | 1 | Active-low frame sync |
| ctrl_o | output | 14 | Control word |
| freq0_o | output | 28 | Frequency word 0 |
| freq1_o | output | 28 | Frequency word 1 |
| phase0_o | output | 12 | Phase word 0 |
| phase1_o | output | 12 | Phase word 1 |
| sel_freq_o | output | 1 | Frequency register select flag |
| sel_phase_o | output | 1 | Phase register select flag |
| pin_ctl_o | output | 1 | Pin/software select flag |
| core_rst_o | output | 1 | Waveform core reset flag |
| clk_off_o | output | 1 | Internal clock disable flag |
| dac_off_o | output | 1 | Converter power-down flag |
| sign_en_o | output | 1 | Sign output enable flag |
| sign_src_o | output | 1 | Sign output source flag |
| sign_div2_o | output | 1 | Sign divide-by-two flag |
| tri_mode_o | output | 1 | Triangle waveform flag |

## Verification
The held low half of paired mode never appears at the ports directly. A stale or misrouted held half only shows when a later frame completes the pair, as a wrong low half in a frequency word. A lone frame that should wait but writes anyway shows one frame earlier. A bit counter that is off by one, or that survives an early sync, shifts every later frame. That fault shows on the first register written after it, a few system cycles after sync rises. A miswired control bit shows on the very next frequency frame, through the wrong update mode or half.

// File: rtl/dds_rx_pkg.sv
package dds_rx_pkg;
    localparam int FRAME_W  = 16;
    localparam int HALF_W   = 14;
    localparam int FREQ_W   = 2 * HALF_W;
    localparam int PHASE_W  = 12;
    localparam int CTRL_W   = HALF_W;
    localparam int FULL_BIT = 13;   // paired-frame mode
    localparam int HIGH_BIT = 12;   // split-mode half pick
    localparam int PSEL_BIT = 13;   // phase register pick in a phase frame

    typedef enum logic [1:0] {
        DST_CTRL  = 2'b00,
        DST_FREQ0 = 2'b01,
        DST_FREQ1 = 2'b10,
        DST_PHASE = 2'b11
    } dst_e;
endpackage

// File: rtl/dds_bit_sync.sv
module dds_bit_sync #(
    parameter int             WIDTH  = 3,
    parameter int             STAGES = 2,
    parameter logic [WIDTH-1:0] INIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{INIT[b]}};
            else        chain_q <= chain_d;
        end

        assign sync_o[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/dds_frame_rx.sv
module dds_frame_rx
    import dds_rx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk,
    input  logic               sdata,
    input  logic               sync_n,
    output logic               frame_vld,
    output logic [FRAME_W-1:0] frame_data
);
    localparam int CNT_W = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic               sclk_prev;
        logic [FRAME_W-1:0] shift;
        logic [CNT_W-1:0]   cnt;
        logic               vld;
        logic [FRAME_W-1:0] data;
    } rx_t;

    rx_t st_d, st_q;
    logic fall;

    always_comb begin
        st_d           = st_q;
        st_d.vld       = 1'b0;
        st_d.sclk_prev = sclk;
        fall           = st_q.sclk_prev && !sclk;
        if (sync_n) begin
            st_d.cnt = '0;
        end else if (fall && (st_q.cnt < CNT_W'(FRAME_W))) begin
            st_d.shift = {st_q.shift[FRAME_W-2:0], sdata};
            st_d.cnt   = st_q.cnt + CNT_W'(1);
            if (st_q.cnt == CNT_W'(FRAME_W - 1)) begin
                st_d.vld  = 1'b1;
                st_d.data = {st_q.shift[FRAME_W-2:0], sdata};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.sclk_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_vld  = st_q.vld;
    assign frame_data = st_q.data;
endmodule

// File: rtl/dds_reg_update.sv
module dds_reg_update
    import dds_rx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_vld,
    input  logic [FRAME_W-1:0] frame_data,
    output logic [CTRL_W-1:0]  ctrl,
    output logic [FREQ_W-1:0]  freq0,
    output logic [FREQ_W-1:0]  freq1,
    output logic [PHASE_W-1:0] phase0,
    output logic [PHASE_W-1:0] phase1,
    output logic               pend
);
    typedef struct packed {
        logic [CTRL_W-1:0]             ctrl;
        logic [1:0][FREQ_W-1:0]        freq;
        logic [1:0][PHASE_W-1:0]       phase;
        logic                          pend;
        logic                          pend_sel;
        logic [HALF_W-1:0]             pend_low;
    } rf_t;

    rf_t rf_d, rf_q;
    dst_e              dst;
    logic [HALF_W-1:0] payload;
    logic              idx;

    always_comb begin
        rf_d    = rf_q;
        dst     = dst_e'(frame_data[FRAME_W-1 -: 2]);
        payload = frame_data[HALF_W-1:0];
        idx     = (dst == DST_FREQ1);
        if (frame_vld) begin
            rf_d.pend = 1'b0;
            case (dst)
                DST_CTRL: rf_d.ctrl = payload;
                DST_FREQ0, DST_FREQ1: begin
                    if (rf_q.ctrl[FULL_BIT]) begin
                        if (rf_q.pend && (rf_q.pend_sel == idx)) begin
                            rf_d.freq[idx] = {payload, rf_q.pend_low};
                        end else begin
                            rf_d.pend     = 1'b1;
                            rf_d.pend_sel = idx;
                            rf_d.pend_low = payload;
                        end
                    end else if (rf_q.ctrl[HIGH_BIT]) begin
                        rf_d.freq[idx][FREQ_W-1:HALF_W] = payload;
                    end else begin
                        rf_d.freq[idx][HALF_W-1:0] = payload;
                    end
                end
                default: rf_d.phase[frame_data[PSEL_BIT]] = frame_data[PHASE_W-1:0];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    assign ctrl   = rf_q.ctrl;
    assign freq0  = rf_q.freq[0];
    assign freq1  = rf_q.freq[1];
    assign phase0 = rf_q.phase[0];
    assign phase1 = rf_q.phase[1];
    assign pend   = rf_q.pend;
endmodule

// File: rtl/dds_regfile.sv
module dds_regfile
    import dds_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_i,
    input  logic               sdata_i,
    input  logic               sync_n_i,
    output logic [CTRL_W-1:0]  ctrl_o,
    output logic [FREQ_W-1:0]  freq0_o,
    output logic [FREQ_W-1:0]  freq1_o,
    output logic [PHASE_W-1:0] phase0_o,
    output logic [PHASE_W-1:0] phase1_o,
    output logic               sel_freq_o,
    output logic               sel_phase_o,
    output logic               pin_ctl_o,
    output logic               core_rst_o,
    output logic               clk_off_o,
    output logic               dac_off_o,
    output logic               sign_en_o,
    output logic               sign_src_o,
    output logic               sign_div2_o,
    output logic               tri_mode_o
);
    logic [2:0]         lines_s;
    logic               frame_vld;
    logic [FRAME_W-1:0] frame_data;
    logic               pend;

    // bit 2: sclk (idle high), bit 1: sync_n (idle high), bit 0: data
    dds_bit_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .INIT(3'b110)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sclk_i, sync_n_i, sdata_i}),
        .sync_o  (lines_s)
    );

    dds_frame_rx u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk       (lines_s[2]),
        .sdata      (lines_s[0]),
        .sync_n     (lines_s[1]),
        .frame_vld  (frame_vld),
        .frame_data (frame_data)
    );

    dds_reg_update u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_vld  (frame_vld),
        .frame_data (frame_data),
        .ctrl       (ctrl_o),
        .freq0      (freq0_o),
        .freq1      (freq1_o),
        .phase0     (phase0_o),
        .phase1     (phase1_o),
        .pend       (pend)
    );

    assign sel_freq_o  = ctrl_o[11];
    assign sel_phase_o = ctrl_o[10];
    assign pin_ctl_o   = ctrl_o[9];
    assign core_rst_o  = ctrl_o[8];
    assign clk_off_o   = ctrl_o[7];
    assign dac_off_o   = ctrl_o[6];
    assign sign_en_o   = ctrl_o[5];
    assign sign_src_o  = ctrl_o[4];
    assign sign_div2_o = ctrl_o[3];
    assign tri_mode_o  = ctrl_o[1];
endmodule

// File: rtl/dds_regfile_chk.sv
module dds_regfile_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        frame_vld,
    input logic [15:0] frame_data,
    input logic        pend,
    input logic [13:0] ctrl,
    input logic [27:0] freq0,
    input logic [27:0] freq1,
    input logic [11:0] phase0,
    input logic [11:0] phase1
);
    logic is_freq;
    assign is_freq = frame_data[15] ^ frame_data[14];

    p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |=> !frame_vld);

    p_quiet_freq_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_vld |=> ($stable(freq0) && $stable(freq1)));

    p_quiet_ctrl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_vld |=> ($stable(ctrl) && $stable(phase0) && $stable(phase1)));

    p_phase_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && frame_data[15:14] == 2'b11)
        |=> ($stable(freq0) && $stable(freq1) && $stable(ctrl)));

    p_first_half_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && is_freq && ctrl[13] && !pend)
        |=> ($stable(freq0) && $stable(freq1) && pend));

    p_drop_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && !is_freq) |=> !pend);
endmodule

bind dds_regfile dds_regfile_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_vld  (frame_vld),
    .frame_data (frame_data),
    .pend       (pend),
    .ctrl       (ctrl_o),
    .freq0      (freq0_o),
    .freq1      (freq1_o),
    .phase0     (phase0_o),
    .phase1     (phase1_o)
);

// File: tb/tb_dds_regfile.sv
module tb_dds_regfile;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1, sdata = 1'b0, sync_n = 1'b1;
    logic [13:0] ctrl;
    logic [27:0] f0, f1;
    logic [11:0] p0, p1;
    logic sel_freq, sel_phase, pin_ctl, core_rst, clk_off, dac_off;
    logic sign_en, sign_src, sign_div2, tri_mode;
    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dds_regfile dut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdata_i(sdata), .sync_n_i(sync_n),
        .ctrl_o(ctrl), .freq0_o(f0), .freq1_o(f1), .phase0_o(p0), .phase1_o(p1),
        .sel_freq_o(sel_freq), .sel_phase_o(sel_phase), .pin_ctl_o(pin_ctl),
        .core_rst_o(core_rst), .clk_off_o(clk_off), .dac_off_o(dac_off),
        .sign_en_o(sign_en), .sign_src_o(sign_src), .sign_div2_o(sign_div2),
        .tri_mode_o(tri_mode)
    );

    typedef struct packed {
        logic [15:0] w;
        logic [27:0] f0;
        logic [27:0] f1;
        logic [11:0] p0;
        logic [11:0] p1;
        logic [13:0] c;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{16'h5234, 28'h0001234, 28'h0,       12'h0,   12'h0,   14'h0000, 4'd5}, // R5 low half
        '{16'h1000, 28'h0001234, 28'h0,       12'h0,   12'h0,   14'h1000, 4'd1}, // R1 control
        '{16'h4ABC, 28'h2AF1234, 28'h0,       12'h0,   12'h0,   14'h1000, 4'd5}, // R5 high half
        '{16'h2000, 28'h2AF1234, 28'h0,       12'h0,   12'h0,   14'h2000, 4'd1}, // R1 paired mode on
        '{16'hBFFF, 28'h2AF1234, 28'h0,       12'h0,   12'h0,   14'h2000, 4'd3}, // R3 held
        '{16'h8001, 28'h2AF1234, 28'h0007FFF, 12'h0,   12'h0,   14'h2000, 4'd3}, // R3 commit
        '{16'h4005, 28'h2AF1234, 28'h0007FFF, 12'h0,   12'h0,   14'h2000, 4'd3}, // R3 held
        '{16'h8002, 28'h2AF1234, 28'h0007FFF, 12'h0,   12'h0,   14'h2000, 4'd4}, // R4 other reg
        '{16'hC123, 28'h2AF1234, 28'h0007FFF, 12'h123, 12'h0,   14'h2000, 4'd2}, // R2 phase 0
        '{16'h8007, 28'h2AF1234, 28'h0007FFF, 12'h123, 12'h0,   14'h2000, 4'd4}, // R4 after drop
        '{16'h8003, 28'h2AF1234, 28'h000C007, 12'h123, 12'h0,   14'h2000, 4'd4}, // R4 pair
        '{16'hF456, 28'h2AF1234, 28'h000C007, 12'h123, 12'h456, 14'h2000, 4'd2}, // R2 phase 1
        '{16'h0FFA, 28'h2AF1234, 28'h000C007, 12'h123, 12'h456, 14'h0FFA, 4'd1}, // R1 control
        '{16'h4777, 28'h2AF0777, 28'h000C007, 12'h123, 12'h456, 14'h0FFA, 4'd5}  // R5 low half
    };

    function automatic string tag_of(input logic [3:0] r);
        case (r)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            default: return "R?";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // R9: MSB first, data changes while sclk is high, taken on the falling edge
    task automatic send(input logic [15:0] word, input int nbits);
        sync_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 15; i > 15 - nbits; i--) begin
            sdata = word[i];
            repeat (4) @(negedge clk);
            sclk = 1'b0;
            repeat (4) @(negedge clk);
            sclk = 1'b1;
        end
        repeat (4) @(negedge clk);
        sync_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    function automatic logic [9:0] flags();
        return {sel_freq, sel_phase, pin_ctl, core_rst, clk_off, dac_off,
                sign_en, sign_src, sign_div2, tri_mode};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R8 reset state
        check("R8", "ctrl",  32'(ctrl), 32'h0);
        check("R8", "freq0", 32'(f0), 32'h0);
        check("R8", "freq1", 32'(f1), 32'h0);
        check("R8", "phase", 32'({p0, p1}), 32'h0);
        check("R8", "flags", 32'(flags()), 32'h0);

        // R9 framing plus table walk
        for (int k = 0; k < NV; k++) begin
            send(VECS[k].w, 16);
            check(tag_of(VECS[k].req), "freq0",  32'(f0),   32'(VECS[k].f0));
            check(tag_of(VECS[k].req), "freq1",  32'(f1),   32'(VECS[k].f1));
            check(tag_of(VECS[k].req), "phase0", 32'(p0),   32'(VECS[k].p0));
            check(tag_of(VECS[k].req), "phase1", 32'(p1),   32'(VECS[k].p1));
            check(tag_of(VECS[k].req), "ctrl",   32'(ctrl), 32'(VECS[k].c));
        end
        check("R9", "serial order", 32'(f0), 32'h2AF0777);

        // R6 flag positions, control word still 0x0FFA
        check("R6", "flags all", 32'(flags()), 32'h3FF);
        send(16'h0A00, 16);
        check("R6", "flags freq+pin", 32'(flags()), 32'(10'b1010000000));
        send(16'h0012, 16);
        check("R6", "flags src+tri", 32'(flags()), 32'(10'b0000000101));
        send(16'h0000, 16);
        check("R6", "flags clear", 32'(flags()), 32'h0);

        // R7 short frame discarded, then recovery
        send(16'h4FFF, 10);
        check("R7", "freq0 after short", 32'(f0), 32'h2AF0777);
        check("R7", "ctrl after short", 32'(ctrl), 32'h0);
        send(16'h4001, 16);
        check("R7", "freq0 after recovery", 32'(f0), 32'h2AF0001);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule